// File: doc/BRIEF.md
# Receive Ring Start-Of-Packet Scanner

This block looks after the receive side of a circular descriptor ring kept in system memory. Each ring entry carries a 32-bit status word in which bit 31 is the ownership flag (1 = owned by the controller, 0 = owned by the host) and bit 25 is the start-of-packet flag. Entry `i` sits at byte address `ring_base + 16*i`, and the ring index wraps to 0 after `ring_len - 1`. The scanner reads status words, and writes them back when it must, through a simple request/grant memory port. The port holds `mem_req` until `mem_gnt`, and read data returns later with `mem_rvalid`.

When the look-ahead enable is 1, a scan started by `start_scan` walks forward through the ring until it reaches an entry whose start-of-packet flag is set. Entries without that flag are passed over whoever owns them. Those owned by the controller are handed back to the host by writing their status word with bit 31 cleared and every other bit unchanged. At the start-of-packet entry the scanner either waits on a poll timer and reads the same entry again (host-owned) or keeps its status word and index and idles (controller-owned). When look-ahead is off, the entry at the current index is taken as it is, polled or kept according to its ownership alone. Once a frame has started (`frame_start`) and its header bytes are in the header buffer (`header_done`), the scanner pulses `hdr_irq` and moves its index past the kept entry.

Top module: `rx_sop_scanner`

## Requirements
- R1: With `la_en` = 1, a status word read with bit 25 = 0 never becomes the kept descriptor. The scanner moves on to the next ring entry until it reads one with bit 25 = 1.
- R2: With `la_en` = 1, a host-owned entry (bit 31 = 0) with bit 25 = 0 does not stop the scan. The scanner reads it once and goes on to the next entry.
- R3: With `la_en` = 1, an entry read with bit 31 = 1 and bit 25 = 0 is written back exactly once, with bit 31 = 0 and all other bits as read, before the next entry is read.
- R4: A host-owned entry with bit 25 = 0 is never written during a look-ahead scan.
- R5: An entry that is due to be kept but is host-owned is read again and again. With a poll interval of N ≥ 1, the next read request for it rises N+1 cycles after the cycle in which its read data returned.
- R6: A controller-owned entry that ends the scan is kept: `desc_valid` = 1, `desc_status` holds the word as read, and `desc_index` holds its index. No memory request is made until the frame is done.
- R7: After `frame_start`, a `header_done` pulse produces exactly one single-cycle `hdr_irq` pulse (one cycle later). `desc_valid` then drops and the index moves to the next entry.
- R8: `la_en` is written by `la_wr` at any time, is 0 after `rst_n` or `soft_rst`, and is not changed by `stop_cmd`.
- R9: Entry addresses are `ring_base + 16*index`. The index stays below `ring_len` (1 to 512) and wraps from `ring_len - 1` to 0.
- R10: A polled entry becomes the kept descriptor once a read returns it with bit 31 = 1.
- R11: With `la_en` = 0, the entry at the current index is kept if bit 31 = 1 and polled if bit 31 = 0, whatever bit 25 holds, and no other entry is read or written.
- R12: `stop_cmd` returns the scanner to idle within one cycle (`mem_req` = 0, `desc_valid` = 0) and keeps the ring index, so the next scan resumes at the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset: idle, index 0, look-ahead off |
| stop_cmd | input | 1 | Stop: return to idle, keep index and enable |
| la_wr | input | 1 | Write strobe for the look-ahead enable |
| la_wdata | input | 1 | Value written to the look-ahead enable |
| la_en | output | 1 | Current look-ahead enable |
| ring_base | input | 32 | Byte address of ring entry 0 |
| ring_len | input | 10 | Number of ring entries, 1 to 512 |
| poll_interval | input | 16 | Poll wait in cycles (0 acts as 1) |
| start_scan | input | 1 | Begin a scan from the current index |
| frame_start | input | 1 | A frame has begun arriving |
| header_done | input | 1 | Header bytes of the frame are stored |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Status word address |
| mem_wdata | output | 32 | Status word written back |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| desc_valid | output | 1 | A descriptor is kept |
| desc_status | output | 32 | Kept status word |
| desc_index | output | 9 | Ring index of the kept entry |
| hdr_irq | output | 1 | Header-stored interrupt pulse |

## Verification
The bench builds the scanner with its defaults (512-entry ring limit, 16-bit poll counter) but drives ring lengths of 3, 4 and 6 with a base of 0x1000. This keeps every wrap from the last entry back to entry 0 within a few dozen cycles. Its memory model grants one cycle after a request and returns read data one cycle after the grant. With a poll interval of 5 the two reads of a polled entry are therefore 8 cycles apart. Poll intervals of 5 and 3 let repeated polling, the hand-over of ownership while polling, and a stop during polling all be checked inside short runs.

// File: rtl/rx_scan_pkg.sv
package rx_scan_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_BIT = 31;
  localparam int SOP_BIT = 25;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_POLL,
    ST_HELD,
    ST_RECV
  } scan_state_e;
endpackage

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int RING_MAX  = 512,
  parameter int ADDR_W    = 32,
  parameter int STRIDE_LG = 4,
  localparam int IDX_W = $clog2(RING_MAX),
  localparam int LEN_W = $clog2(RING_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [LEN_W-1:0]  ring_len,
  input  logic [ADDR_W-1:0] ring_base,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  logic [IDX_W-1:0] idx_nxt;
  logic             at_last;
  logic             idx_en;

  assign at_last = ({1'b0, idx} == (ring_len - LEN_W'(1)));
  assign idx_en  = clr | adv;

  always_comb begin
    idx_nxt = idx;
    if (clr) begin
      idx_nxt = '0;
    end else if (adv) begin
      idx_nxt = at_last ? '0 : idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_nxt;
    end
  end

  assign addr = ring_base + (ADDR_W'(idx) << STRIDE_LG);

  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx} < ring_len));

  // R9
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && at_last) |=> (idx == '0));
endmodule

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] interval,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             at_end;

  assign at_end  = (cnt <= CNT_W'(1));
  assign expired = run & at_end;
  assign cnt_en  = load | (run & ~at_end);

  always_comb begin
    cnt_nxt = cnt;
    if (load) begin
      cnt_nxt = interval;
    end else if (run && !at_end) begin
      cnt_nxt = cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  // R5
  poll_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !run);
endmodule

// File: rtl/rx_scan_fsm.sv
module rx_scan_fsm
  import rx_scan_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop_cmd,
  input  logic              la_en,
  input  logic              start_scan,
  input  logic              frame_start,
  input  logic              header_done,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              poll_expired,
  input  logic [IDX_W-1:0]  idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              idx_adv,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic              desc_valid,
  output logic [WORD_W-1:0] desc_status,
  output logic [IDX_W-1:0]  desc_index,
  output logic              hdr_irq
);
  scan_state_e       st;
  scan_state_e       st_nxt;
  logic              abort;
  logic              cap_rd;
  logic              cap_desc;
  logic              hdr_irq_nxt;
  logic              rd_own;
  logic              rd_sop;
  logic [WORD_W-1:0] rd_word;

  assign abort  = stop_cmd | soft_rst;
  assign rd_own = mem_rdata[OWN_BIT];
  assign rd_sop = mem_rdata[SOP_BIT];

  always_comb begin
    st_nxt   = st;
    idx_adv  = 1'b0;
    tmr_load = 1'b0;
    cap_rd   = 1'b0;
    cap_desc = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start_scan) st_nxt = ST_RD_REQ;
      end
      ST_RD_REQ: begin
        if (mem_gnt) st_nxt = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rvalid) begin
          cap_rd = 1'b1;
          if (la_en && !rd_sop) begin
            if (rd_own) begin
              st_nxt = ST_WR_REQ;
            end else begin
              idx_adv = 1'b1;
              st_nxt  = ST_RD_REQ;
            end
          end else if (rd_own) begin
            cap_desc = 1'b1;
            st_nxt   = ST_HELD;
          end else begin
            tmr_load = 1'b1;
            st_nxt   = ST_POLL;
          end
        end
      end
      ST_WR_REQ: begin
        if (mem_gnt) begin
          idx_adv = 1'b1;
          st_nxt  = ST_RD_REQ;
        end
      end
      ST_POLL: begin
        if (poll_expired) st_nxt = ST_RD_REQ;
      end
      ST_HELD: begin
        if (frame_start) st_nxt = ST_RECV;
      end
      ST_RECV: begin
        if (header_done) begin
          idx_adv = 1'b1;
          st_nxt  = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
    if (abort) begin
      st_nxt   = ST_IDLE;
      idx_adv  = 1'b0;
      tmr_load = 1'b0;
      cap_rd   = 1'b0;
      cap_desc = 1'b0;
    end
  end

  assign hdr_irq_nxt = (st == ST_RECV) & header_done & ~abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      hdr_irq <= 1'b0;
    end else begin
      st      <= st_nxt;
      hdr_irq <= hdr_irq_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
    end else if (cap_rd) begin
      rd_word <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_status <= '0;
      desc_index  <= '0;
    end else if (cap_desc) begin
      desc_status <= mem_rdata;
      desc_index  <= idx;
    end
  end

  assign mem_req    = (st == ST_RD_REQ) | (st == ST_WR_REQ);
  assign mem_we     = (st == ST_WR_REQ);
  assign mem_wdata  = rd_word & ~(WORD_W'(1) << OWN_BIT);
  assign tmr_run    = (st == ST_POLL);
  assign desc_valid = (st == ST_HELD) | (st == ST_RECV);

  // R3
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

  // R6
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !mem_req);

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_irq |=> !hdr_irq);

  // R1
  sop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RD_WAIT) && mem_rvalid && la_en && !mem_rdata[SOP_BIT])
      |=> !desc_valid);

  // R12
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> (!mem_req && !desc_valid));
endmodule

// File: rtl/rx_sop_scanner.sv
module rx_sop_scanner
  import rx_scan_pkg::*;
#(
  parameter int RING_MAX  = 512,
  parameter int ADDR_W    = 32,
  parameter int POLL_W    = 16,
  parameter int STRIDE_LG = 4,
  localparam int IDX_W = $clog2(RING_MAX),
  localparam int LEN_W = $clog2(RING_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop_cmd,
  input  logic              la_wr,
  input  logic              la_wdata,
  output logic              la_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LEN_W-1:0]  ring_len,
  input  logic [POLL_W-1:0] poll_interval,
  input  logic              start_scan,
  input  logic              frame_start,
  input  logic              header_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              desc_valid,
  output logic [WORD_W-1:0] desc_status,
  output logic [IDX_W-1:0]  desc_index,
  output logic              hdr_irq
);
  logic             la_nxt;
  logic             la_upd;
  logic             idx_adv;
  logic             tmr_load;
  logic             tmr_run;
  logic             tmr_exp;
  logic [IDX_W-1:0] idx;

  assign la_upd = soft_rst | la_wr;

  always_comb begin
    la_nxt = la_en;
    if (soft_rst) begin
      la_nxt = 1'b0;
    end else if (la_wr) begin
      la_nxt = la_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_en <= 1'b0;
    end else if (la_upd) begin
      la_en <= la_nxt;
    end
  end

  rx_ring_ptr #(
    .RING_MAX  (RING_MAX),
    .ADDR_W    (ADDR_W),
    .STRIDE_LG (STRIDE_LG)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_rst),
    .adv       (idx_adv),
    .ring_len  (ring_len),
    .ring_base (ring_base),
    .idx       (idx),
    .addr      (mem_addr)
  );

  rx_poll_timer #(
    .CNT_W (POLL_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .run      (tmr_run),
    .interval (poll_interval),
    .expired  (tmr_exp)
  );

  rx_scan_fsm #(
    .IDX_W (IDX_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .stop_cmd     (stop_cmd),
    .la_en        (la_en),
    .start_scan   (start_scan),
    .frame_start  (frame_start),
    .header_done  (header_done),
    .mem_gnt      (mem_gnt),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .poll_expired (tmr_exp),
    .idx          (idx),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_wdata    (mem_wdata),
    .idx_adv      (idx_adv),
    .tmr_load     (tmr_load),
    .tmr_run      (tmr_run),
    .desc_valid   (desc_valid),
    .desc_status  (desc_status),
    .desc_index   (desc_index),
    .hdr_irq      (hdr_irq)
  );

  // R8
  la_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !la_en);

  // R8
  la_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && !soft_rst && !la_wr) |=> (la_en == $past(la_en)));
endmodule

// File: tb/sim_rx_sop_scanner.sv
module sim_rx_sop_scanner;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] SOP  = 32'h0200_0000;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, stop_cmd = 1'b0, la_wr = 1'b0, la_wdata = 1'b0;
  logic        la_en;
  logic [31:0] ring_base = BASE;
  logic [9:0]  ring_len = 10'd4;
  logic [15:0] poll_interval = 16'd5;
  logic        start_scan = 1'b0, frame_start = 1'b0, header_done = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        desc_valid;
  logic [31:0] desc_status;
  logic [8:0]  desc_index;
  logic        hdr_irq;

  logic [31:0] mem [NE];
  int rd_cnt [NE];
  int wr_cnt [NE];
  int rd_last [NE];
  int rd_prev [NE];
  int oob = 0;
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_sop_scanner u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (mem_req && !mem_gnt) mem_gnt <= 1'b1;
    else mem_gnt <= 1'b0;
    if (mem_req && mem_gnt) begin
      int e;
      e = int'((mem_addr - ring_base) >> 4);
      if (mem_addr[3:0] != 4'h0 || mem_addr < ring_base || e >= int'(ring_len) || e >= NE) begin
        oob <= oob + 1;
      end else if (mem_we) begin
        mem[e] <= mem_wdata;
        wr_cnt[e] <= wr_cnt[e] + 1;
      end else begin
        mem_rdata <= mem[e];
        mem_rvalid <= 1'b1;
        rd_cnt[e] <= rd_cnt[e] + 1;
        rd_prev[e] <= rd_last[e];
        rd_last[e] <= cyc;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    for (int i = 0; i < NE; i++) begin
      rd_cnt[i] = 0; wr_cnt[i] = 0; rd_last[i] = 0; rd_prev[i] = 0;
    end
    oob = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic do_soft_rst();
    pulse(soft_rst);
    @(negedge clk);
  endtask

  task automatic set_la(input logic v);
    la_wdata = v;
    pulse(la_wr);
  endtask

  task automatic wait_kept(input int lim);
    for (int i = 0; i < lim && !desc_valid; i++) @(negedge clk);
  endtask

  task automatic finish_frame();
    int irqs;
    irqs = 0;
    pulse(frame_start);
    @(negedge clk);
    header_done = 1'b1;
    @(negedge clk);
    header_done = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (hdr_irq) irqs++;
      @(negedge clk);
    end
    chk("R7 irq pulse count", irqs, 1);
    chk("R7 desc_valid after header", desc_valid, 0);
  endtask

  task automatic t_reset();
    chk("R8 la_en after reset", la_en, 0);
    chk("R6 desc_valid after reset", desc_valid, 0);
    chk("R12 mem_req after reset", mem_req, 0);
    chk("R7 hdr_irq after reset", hdr_irq, 0);
    set_la(1'b1);
    chk("R8 la_en written", la_en, 1);
    set_la(1'b0);
    chk("R8 la_en cleared by write", la_en, 0);
  endtask

  task automatic t_skip();
    int reqs;
    do_soft_rst();
    ring_len = 10'd6;
    set_la(1'b1);
    for (int i = 0; i < NE; i++) mem[i] = 32'h0;
    mem[0] = OWN | 32'h11;
    mem[1] = 32'h22;
    mem[2] = OWN | SOP | 32'h33;
    clr_stats();
    pulse(start_scan);
    wait_kept(200);
    chk("R1 kept index is first sop", desc_index, 2);
    chk("R6 kept status", desc_status, OWN | SOP | 32'h33);
    chk("R3 owned non-sop returned to host", mem[0], 32'h11);
    chk("R3 single write-back", wr_cnt[0], 1);
    chk("R4 host entry untouched", mem[1], 32'h22);
    chk("R4 host entry not written", wr_cnt[1], 0);
    chk("R2 host entry read once", rd_cnt[1], 1);
    chk("R6 kept entry not written", wr_cnt[2], 0);
    reqs = 0;
    for (int i = 0; i < 10; i++) begin
      if (mem_req) reqs++;
      @(negedge clk);
    end
    chk("R6 quiet while kept", reqs, 0);
    chk("R9 addresses in ring", oob, 0);
    finish_frame();
  endtask

  task automatic t_wrap();
    do_soft_rst();
    ring_len = 10'd3;
    set_la(1'b1);
    mem[0] = OWN | SOP | 32'h44;
    mem[1] = 32'h55;
    mem[2] = OWN | 32'h66;
    clr_stats();
    pulse(start_scan);
    wait_kept(200);
    chk("R6 entry 0 kept", desc_index, 0);
    finish_frame();
    mem[0] = OWN | SOP | 32'h77;
    pulse(start_scan);
    wait_kept(200);
    chk("R9 wrap back to entry 0", desc_index, 0);
    chk("R9 wrap kept status", desc_status, OWN | SOP | 32'h77);
    chk("R3 entry 2 returned", mem[2], 32'h66);
    chk("R9 entry 0 read twice", rd_cnt[0], 2);
    chk("R9 no address outside ring", oob, 0);
    finish_frame();
  endtask

  task automatic t_poll();
    do_soft_rst();
    ring_len = 10'd4;
    poll_interval = 16'd5;
    set_la(1'b1);
    mem[0] = 32'h88;
    mem[1] = SOP | 32'h99;
    mem[2] = 32'h0;
    clr_stats();
    pulse(start_scan);
    for (int i = 0; i < 200 && rd_cnt[1] < 3; i++) @(negedge clk);
    chk("R5 polled entry read repeatedly", rd_cnt[1] >= 3, 1);
    chk("R5 poll gap cycles", rd_last[1] - rd_prev[1], 8);
    chk("R5 not kept while host-owned", desc_valid, 0);
    chk("R5 polled entry not written", wr_cnt[1], 0);
    chk("R2 next entry not read", rd_cnt[2], 0);
    mem[1] = OWN | SOP | 32'h99;
    wait_kept(200);
    chk("R10 kept after ownership arrives", desc_index, 1);
    chk("R10 kept status", desc_status, OWN | SOP | 32'h99);
    finish_frame();
  endtask

  task automatic t_noskip();
    do_soft_rst();
    chk("R8 soft reset clears enable", la_en, 0);
    ring_len = 10'd4;
    poll_interval = 16'd3;
    mem[0] = OWN | 32'hAA;
    mem[1] = 32'hBB;
    mem[2] = OWN | SOP | 32'hCC;
    clr_stats();
    pulse(start_scan);
    wait_kept(200);
    chk("R11 non-sop owned entry kept", desc_index, 0);
    chk("R11 kept status as read", desc_status, OWN | 32'hAA);
    chk("R11 nothing written", wr_cnt[0], 0);
    finish_frame();
    pulse(start_scan);
    for (int i = 0; i < 40; i++) @(negedge clk);
    chk("R11 host entry polled", rd_cnt[1] >= 2, 1);
    chk("R11 no skip to next entry", rd_cnt[2], 0);
    chk("R11 not kept", desc_valid, 0);
    set_la(1'b1);
    pulse(stop_cmd);
    chk("R12 mem_req low after stop", mem_req, 0);
    chk("R8 stop keeps enable", la_en, 1);
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk("R12 idle after stop", mem_req, 0);
    set_la(1'b0);
    mem[1] = OWN | 32'hBB;
    pulse(start_scan);
    wait_kept(200);
    chk("R12 index kept over stop", desc_index, 1);
    pulse(stop_cmd);
    chk("R12 desc_valid cleared by stop", desc_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) mem[i] = 32'h0;
    clr_stats();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_skip();
    t_wrap();
    t_poll();
    t_noskip();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule